// File: doc/BRIEF.md
# Barrel Thread Sequencer

This block is the thread-control core of a processor that runs four hardware threads on one five-stage pipeline without forwarding paths. On every clock edge the issue slot passes to the next thread in a fixed ring. Each thread keeps its own program counter and its own bank of sixteen 32-bit registers inside the block, so a switch never spills state anywhere.

Every issued slot is stamped with the issuing thread's number. The stamp moves one stage per clock alongside the instruction. The decode stage reads operands from the bank named by its stamp, and the writeback stage writes into the bank named by its own stamp. The thread issuing at that moment plays no part in either access.

Because one thread issues only every fourth cycle, an instruction's producer has left the stages that could conflict before its next instruction reads. For that reason the surrounding pipeline needs no hazard interlock. A branch unit may steer any single thread by naming it on the redirect port.

Top module: `barrel_thread_seq`

## Requirements
- R1: While reset is held and right after its release, `fetch_tid` is 0, every thread's PC equals `RESET_VEC`, and stages 1 to 4 report invalid in `stage_vld`. Stage 0 is always valid.
- R2: `fetch_tid` advances by one on each clock edge in the order 0, 1, 2, 3 and then wraps to 0.
- R3: `fetch_addr` shows the PC of the thread in `fetch_tid`. At the edge that ends its issue cycle, that PC grows by 4. The PCs of the other threads do not change at that edge.
- R4: When `redir_vld` is high at an edge, the PC of thread `redir_tid` takes `redir_tgt`. This wins over the +4 step if that thread is issuing in the same cycle. No other thread's PC is affected.
- R5: `stage_tid` holds one 2-bit field per stage, with stage s at bits [2s+1:2s]. Stage 0 is the fetch thread. Stage s holds the thread that was fetching s edges earlier. Its bit in `stage_vld` is set once at least s edges have passed since reset.
- R6: `rd_data_a` and `rd_data_b` show, combinationally, the registers `rd_idx_a` and `rd_idx_b` of the thread tagged in stage 1.
- R7: At an edge where `wb_vld` and `stage_vld[4]` are both high, register `wb_idx` of the thread in stage 4 (also shown on `wb_tid`) takes `wb_data`. The same index in every other thread is left unchanged.
- R8: When `wb_vld` is low, no register changes, whatever `wb_idx` and `wb_data` carry.
- R9: While stages 1 to 3 are valid, none of them holds the same thread as stage 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redir_vld | input | 1 | Branch redirect strobe |
| redir_tid | input | 2 | Thread whose PC is redirected |
| redir_tgt | input | 32 | New PC for that thread |
| rd_idx_a | input | 4 | Operand A register index (decode stage) |
| rd_idx_b | input | 4 | Operand B register index (decode stage) |
| wb_vld | input | 1 | Writeback strobe |
| wb_idx | input | 4 | Writeback register index |
| wb_data | input | 32 | Writeback value |
| fetch_addr | output | 32 | PC of the issuing thread |
| fetch_tid | output | 2 | Issuing thread |
| stage_tid | output | 10 | Thread tags of stages 0 to 4, two bits each |
| stage_vld | output | 5 | Slot valid per stage |
| rd_data_a | output | 32 | Operand A value |
| rd_data_b | output | 32 | Operand B value |
| wb_tid | output | 2 | Thread that owns the writeback slot |

## Verification
Fetch thread and PC steps are due one edge after the issue cycle. A redirect lands in the PC at the next edge and appears on `fetch_addr` the next time that thread issues, up to four edges later. A stage tag is due s edges after its fetch, operand reads are due in the same cycle as the index, and a writeback can be read from the first cycle after its edge. The bench changes inputs and samples outputs on the falling edge. It steps a model of the PCs and the ring on every rising edge and waits for the stage tag it needs before it drives a read or a write. Each comparison therefore falls in the cycle its result is due.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  // Stage numbering used across the sequencer
  localparam int STG_FETCH = 0;
  localparam int STG_READ  = 1;
  localparam int STG_EXEC  = 2;
  localparam int STG_MEM   = 3;
  localparam int STG_WB    = 4;
  localparam int NUM_STG   = 5;
endpackage

// File: rtl/thread_rotor.sv
module thread_rotor #(
  parameter int THREADS = 4,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [TID_W-1:0] cur_tid
);
  logic [TID_W-1:0] cur_q, cur_nxt;
  logic             last;

  always_comb begin
    last    = (cur_q == TID_W'(THREADS - 1));
    cur_nxt = last ? '0 : cur_q + TID_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_nxt;
  end

  assign cur_tid = cur_q;

  // R2
  tid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cur_q == (($past(cur_q) == TID_W'(THREADS - 1)) ? '0 : $past(cur_q) + TID_W'(1))));
endmodule

// File: rtl/pc_bank.sv
module pc_bank #(
  parameter int          THREADS   = 4,
  parameter int          PC_W      = 32,
  parameter int          PC_STEP   = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  localparam int TID_W = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TID_W-1:0] fetch_tid,
  input  logic             redir_vld,
  input  logic [TID_W-1:0] redir_tid,
  input  logic [PC_W-1:0]  redir_tgt,
  output logic [PC_W-1:0]  fetch_addr
);
  logic [PC_W-1:0] pc_q   [THREADS];
  logic [PC_W-1:0] pc_nxt [THREADS];
  logic [THREADS-1:0] pc_en;
  logic [THREADS-1:0] redir_hit;

  for (genvar t = 0; t < THREADS; t++) begin : g_pc
    always_comb begin
      redir_hit[t] = redir_vld && (redir_tid == TID_W'(t));
      pc_en[t]     = redir_hit[t] || (fetch_tid == TID_W'(t));
      pc_nxt[t]    = redir_hit[t] ? redir_tgt : pc_q[t] + PC_W'(PC_STEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q[t] <= RESET_VEC[PC_W-1:0];
      else if (pc_en[t]) pc_q[t] <= pc_nxt[t];
    end
  end

  assign fetch_addr = pc_q[fetch_tid];

  // R3
  pc_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_vld && redir_tid == fetch_tid) |=>
      (pc_q[$past(fetch_tid)] == $past(fetch_addr) + PC_W'(PC_STEP)));

  // R4
  redir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld |=> (pc_q[$past(redir_tid)] == $past(redir_tgt)));
endmodule

// File: rtl/tid_pipe.sv
module tid_pipe #(
  parameter int STAGES = 5,
  parameter int TID_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [TID_W-1:0]        in_tid,
  output logic [STAGES*TID_W-1:0] tag_flat,
  output logic [STAGES-1:0]       vld
);
  logic [TID_W-1:0] tag_c [STAGES];
  logic [STAGES-1:0] vld_c;

  assign tag_c[0] = in_tid;
  assign vld_c[0] = 1'b1;

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    logic [TID_W-1:0] tag_q;
    logic             vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        vld_q <= 1'b0;
      end else begin
        tag_q <= tag_c[s-1];
        vld_q <= vld_c[s-1];
      end
    end

    assign tag_c[s] = tag_q;
    assign vld_c[s] = vld_q;

    // R5
    tag_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tag_q == $past(tag_c[s-1]) && vld_q == $past(vld_c[s-1])));
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_flat
    assign tag_flat[s*TID_W +: TID_W] = tag_c[s];
  end

  assign vld = vld_c;
endmodule

// File: rtl/thread_regfile.sv
module thread_regfile #(
  parameter int THREADS = 4,
  parameter int NREG    = 16,
  parameter int DATA_W  = 32,
  localparam int TID_W  = $clog2(THREADS),
  localparam int IDX_W  = $clog2(NREG),
  localparam int ADDR_W = TID_W + IDX_W,
  localparam int DEPTH  = THREADS * NREG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic [IDX_W-1:0]  rd_idx_a,
  input  logic [IDX_W-1:0]  rd_idx_b,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_addr, rd_addr_a, rd_addr_b;

  assign wr_addr   = {wr_tid, wr_idx};
  assign rd_addr_a = {rd_tid, rd_idx_a};
  assign rd_addr_b = {rd_tid, rd_idx_b};

  // Data array carries no reset; every entry has its own write enable
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_addr == ADDR_W'(e));
    always_ff @(posedge clk) begin
      if (ent_en) mem[e] <= wr_data;
    end
  end

  assign rd_data_a = mem[rd_addr_a];
  assign rd_data_b = mem[rd_addr_b];

  // R7
  wb_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/barrel_thread_seq.sv
module barrel_thread_seq #(
  parameter int          THREADS   = 4,
  parameter int          PC_W      = 32,
  parameter int          PC_STEP   = 4,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000,
  parameter int          NREG      = 16,
  parameter int          DATA_W    = 32,
  localparam int TID_W  = $clog2(THREADS),
  localparam int IDX_W  = $clog2(NREG),
  localparam int STAGES = barrel_pkg::NUM_STG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    redir_vld,
  input  logic [TID_W-1:0]        redir_tid,
  input  logic [PC_W-1:0]         redir_tgt,
  input  logic [IDX_W-1:0]        rd_idx_a,
  input  logic [IDX_W-1:0]        rd_idx_b,
  input  logic                    wb_vld,
  input  logic [IDX_W-1:0]        wb_idx,
  input  logic [DATA_W-1:0]       wb_data,
  output logic [PC_W-1:0]         fetch_addr,
  output logic [TID_W-1:0]        fetch_tid,
  output logic [STAGES*TID_W-1:0] stage_tid,
  output logic [STAGES-1:0]       stage_vld,
  output logic [DATA_W-1:0]       rd_data_a,
  output logic [DATA_W-1:0]       rd_data_b,
  output logic [TID_W-1:0]        wb_tid
);
  import barrel_pkg::*;

  logic [TID_W-1:0] cur_tid;
  logic [TID_W-1:0] read_tid;
  logic             wr_en;

  thread_rotor #(.THREADS(THREADS)) u_rotor (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur_tid (cur_tid)
  );

  pc_bank #(
    .THREADS   (THREADS),
    .PC_W      (PC_W),
    .PC_STEP   (PC_STEP),
    .RESET_VEC (RESET_VEC)
  ) u_pcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_tid  (cur_tid),
    .redir_vld  (redir_vld),
    .redir_tid  (redir_tid),
    .redir_tgt  (redir_tgt),
    .fetch_addr (fetch_addr)
  );

  tid_pipe #(.STAGES(STAGES), .TID_W(TID_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_tid   (cur_tid),
    .tag_flat (stage_tid),
    .vld      (stage_vld)
  );

  assign read_tid = stage_tid[STG_READ*TID_W +: TID_W];
  assign wb_tid   = stage_tid[STG_WB*TID_W +: TID_W];
  assign wr_en    = wb_vld && stage_vld[STG_WB];

  thread_regfile #(
    .THREADS (THREADS),
    .NREG    (NREG),
    .DATA_W  (DATA_W)
  ) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_tid    (read_tid),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b),
    .wr_en     (wr_en),
    .wr_tid    (wb_tid),
    .wr_idx    (wb_idx),
    .wr_data   (wb_data)
  );

  assign fetch_tid = cur_tid;

  for (genvar s = 1; s < THREADS && s < STAGES; s++) begin : g_sep
    // R9
    inflight_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_vld[s] |-> (stage_tid[s*TID_W +: TID_W] != cur_tid));
  end
endmodule

// File: tb/test_barrel_thread_seq.sv
`timescale 1ns/1ps
module test_barrel_thread_seq;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redir_vld;
  logic [1:0]  redir_tid;
  logic [31:0] redir_tgt;
  logic [3:0]  rd_idx_a, rd_idx_b;
  logic        wb_vld;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;
  logic [31:0] fetch_addr;
  logic [1:0]  fetch_tid;
  logic [9:0]  stage_tid;
  logic [4:0]  stage_vld;
  logic [31:0] rd_data_a, rd_data_b;
  logic [1:0]  wb_tid;

  int vec_n  = 0;
  int miss_n = 0;

  // reference state
  logic [1:0]  m_tid;
  logic [31:0] m_pc [4];
  int          m_cnt;
  logic [31:0] m_rf [64];

  always #2 clk = ~clk;

  barrel_thread_seq i_barrel_thread_seq (
    .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .redir_tid(redir_tid),
    .redir_tgt(redir_tgt), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_data(wb_data),
    .fetch_addr(fetch_addr), .fetch_tid(fetch_tid), .stage_tid(stage_tid),
    .stage_vld(stage_vld), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
    .wb_tid(wb_tid)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tid <= 2'd0;
      m_cnt <= 0;
      for (int t = 0; t < 4; t++) m_pc[t] <= RV;
    end else begin
      if (redir_vld) m_pc[redir_tid] <= redir_tgt;
      if (!(redir_vld && redir_tid == m_tid)) m_pc[m_tid] <= m_pc[m_tid] + 32'd4;
      m_tid <= m_tid + 2'd1;
      if (m_cnt < 100) m_cnt <= m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec_n++;
    if (!ok) begin
      miss_n++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] tag_at(input int s);
    return stage_tid[s*2 +: 2];
  endfunction

  task automatic check_slot();
    chk(fetch_tid == m_tid, "R2 fetch thread", 64'(fetch_tid), 64'(m_tid));
    chk(fetch_addr == m_pc[m_tid], "R3 fetch address", 64'(fetch_addr), 64'(m_pc[m_tid]));
    for (int s = 1; s < 5; s++) begin
      logic [1:0] et;
      et = m_tid - 2'(s);
      chk(stage_vld[s] == (m_cnt >= s), "R5 stage valid", 64'(stage_vld[s]), 64'(m_cnt >= s));
      if (m_cnt >= s) begin
        chk(tag_at(s) == et, "R5 stage tag", 64'(tag_at(s)), 64'(et));
        if (s < 4) chk(tag_at(s) != fetch_tid, "R9 no repeat in flight", 64'(tag_at(s)), 64'(fetch_tid));
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; redir_vld = 1'b0; redir_tid = '0; redir_tgt = '0;
    rd_idx_a = '0; rd_idx_b = '0; wb_vld = 1'b0; wb_idx = '0; wb_data = '0;
    repeat (3) @(negedge clk);
    chk(fetch_tid == 2'd0, "R1 reset thread", 64'(fetch_tid), 64'd0);
    chk(fetch_addr == RV, "R1 reset pc", 64'(fetch_addr), 64'(RV));
    chk(stage_vld == 5'b00001, "R1 reset valids", 64'(stage_vld), 64'h1);
    rst_n = 1'b1;
    #0.5;
    chk(fetch_addr == RV && fetch_tid == 2'd0, "R1 after release", 64'(fetch_addr), 64'(RV));
  endtask

  task automatic t_rotation();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check_slot();
      chk(fetch_tid == 2'((i + 1) % 4), "R2 ring order", 64'(fetch_tid), 64'((i + 1) % 4));
    end
    // after 20 edges each thread issued five times: RV + 20
    chk(m_pc[0] == RV + 32'd20, "R3 pc step count", 64'(m_pc[0]), 64'(RV + 32'd20));
  endtask

  task automatic t_redirect_other();
    @(negedge clk);
    while (fetch_tid != 2'd0) @(negedge clk);
    redir_vld = 1'b1; redir_tid = 2'd2; redir_tgt = 32'h0000_8000;
    @(negedge clk);
    redir_vld = 1'b0;
    for (int i = 0; i < 8; i++) begin
      check_slot();
      if (fetch_tid == 2'd2 && i < 4)
        chk(fetch_addr == 32'h0000_8000, "R4 redirect target", 64'(fetch_addr), 64'h8000);
      @(negedge clk);
    end
  endtask

  task automatic t_redirect_same();
    while (fetch_tid != 2'd1) @(negedge clk);
    redir_vld = 1'b1; redir_tid = 2'd1; redir_tgt = 32'h0000_9000;
    @(negedge clk);
    redir_vld = 1'b0;
    while (fetch_tid != 2'd1) begin check_slot(); @(negedge clk); end
    chk(fetch_addr == 32'h0000_9000, "R4 redirect beats step", 64'(fetch_addr), 64'h9000);
    check_slot();
  endtask

  task automatic rf_write(input logic [1:0] t, input logic [3:0] idx, input logic [31:0] d, input bit en);
    @(negedge clk);
    while (tag_at(4) != t) @(negedge clk);
    chk(wb_tid == t, "R7 writeback owner", 64'(wb_tid), 64'(t));
    wb_vld = en; wb_idx = idx; wb_data = d;
    @(negedge clk);
    wb_vld = 1'b0; wb_idx = '0; wb_data = '0;
    if (en) m_rf[{t, idx}] = d;
  endtask

  task automatic rf_read(input logic [1:0] t, input logic [3:0] idx, input string req);
    @(negedge clk);
    while (tag_at(1) != t) @(negedge clk);
    rd_idx_a = idx; rd_idx_b = idx;
    #0.5;
    chk(rd_data_a == m_rf[{t, idx}], req, 64'(rd_data_a), 64'(m_rf[{t, idx}]));
    chk(rd_data_b == m_rf[{t, idx}], {req, " port b"}, 64'(rd_data_b), 64'(m_rf[{t, idx}]));
  endtask

  task automatic t_isolation();
    for (int t = 0; t < 4; t++) rf_write(2'(t), 4'd5, 32'hA000_0000 + 32'(t), 1'b1);
    for (int t = 0; t < 4; t++) rf_read(2'(t), 4'd5, "R6 R7 per-thread read");
    rf_write(2'd2, 4'd5, 32'hDEAD_0002, 1'b1);
    for (int t = 0; t < 4; t++) rf_read(2'(t), 4'd5, "R7 isolation after rewrite");
    rf_write(2'd3, 4'd9, 32'h1234_5678, 1'b1);
    rf_read(2'd3, 4'd9, "R6 other index");
  endtask

  task automatic t_no_write();
    rf_write(2'd1, 4'd5, 32'hFFFF_FFFF, 1'b0);
    rf_read(2'd1, 4'd5, "R8 strobe low keeps value");
    rf_write(2'd3, 4'd9, 32'h0BAD_0BAD, 1'b0);
    rf_read(2'd3, 4'd9, "R8 strobe low other thread");
  endtask

  initial begin
    #(200000 * 4);
    miss_n++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

  initial begin
    t_reset();
    t_rotation();
    t_redirect_other();
    t_redirect_same();
    t_isolation();
    t_no_write();
    @(negedge clk);
    check_slot();
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end
endmodule